// File: doc/BRIEF.md
# PCM Serial Word Transmitter

This block puts one 8-bit PCM sample per frame onto a shared serial highway. An external bit clock and frame sync set the timing. The block owns both the serial data bit and the enable that drives the highway's tri-state buffer, so it decides exactly when it may occupy the bus. Both inputs are oversampled on a fast system clock. After a short synchronizer, all timing decisions are made on detected bit-clock edges.

Two frame sync timings are supported. A mode input, which comes from an external timing detector, selects between them.
- **Long sync:** the word starts when sync and bit clock are high together. The driver stays on until the middle of the last bit or until sync drops, whichever is later.
- **Short sync:** a one-bit pre-pulse, sampled on a falling bit-clock edge, announces the word. The word then starts on the next rising edge and ends in the middle of the last bit.

After reset, or after leaving power-down, a guard keeps the driver off for a fixed number of frames. This prevents collisions on a highway that other devices may already be using.

Top module: `pcm_word_tx`

## Requirements
- R1: While `rst` is high and after reset, `sdo_en` and `sdo` are 0 until a frame is sent.
- R2: After reset or after `pdn` is released, the first GUARD_FRAMES frame starts (default 2) produce no drive. The next frame is sent.
- R3: With `long_mode`=1, a frame starts where `fsync` and `bclk` are first both high. `sdo_en` rises and the MSB appears there.
- R4: With `long_mode`=1, `sdo_en` stays high until the falling `bclk` edge in the eighth bit period or the fall of `fsync`, whichever is later. This gives 7.5 bit periods when sync is short, and sync length otherwise.
- R5: With `long_mode`=0, `fsync` high at a falling `bclk` edge arms a frame. `sdo_en` rises with the MSB on the following rising edge.
- R6: With `long_mode`=0, `sdo_en` falls at the falling `bclk` edge in the eighth bit period.
- R7: The bits go out MSB first. A new bit appears only on a rising `bclk` edge.
- R8: `din` is stored on `load`. The stored word is copied to the shifter at frame start, so a load during a frame takes effect on the next frame.
- R9: `pdn` high turns the driver off at once (within the synchronizer latency), ends the frame and restarts the guard.
- R10: Outputs react SYNC_STAGES+1 system clocks after an edge at the `bclk`, `fsync` or `pdn` pins.
- R11: `sdo` is 0 whenever `sdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Stores `din` as the next word |
| din | input | WORD_W | Parallel PCM word |
| bclk | input | 1 | Serial bit clock (asynchronous, oversampled) |
| fsync | input | 1 | Frame sync (asynchronous, oversampled) |
| long_mode | input | 1 | 1 = long sync timing, 0 = short sync timing |
| pdn | input | 1 | Power-down, active high |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Enable for the highway tri-state driver |

## Verification
The assertions assume the following about the inputs:
- `long_mode` is steady while a frame is in progress.
- Each bit-clock phase lasts several system clocks, so rising and falling edges never merge.
- A short sync pulse covers exactly one falling edge.

The stimulus meets these assumptions:
- It uses a bit clock of eight system clocks per period.
- It changes the mode and loads words only between frames, except in the single case that tests a load during a frame.
- It raises long syncs during the low half of the bit clock.
- It holds short syncs across one falling edge only.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_SEND = 2'd2,
    ST_TAIL = 2'd3
  } tx_state_e;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic pdn_i,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic fs_lvl,
  output logic and_rise,
  output logic pdn_lvl
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] chain [STAGES];
  logic [NSIG-1:0] last_q;
  logic [NSIG-1:0] last;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= {pdn_i, fs_i, bclk_i};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign last = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= last;
  end

  assign bclk_rise = last[0] & ~last_q[0];
  assign bclk_fall = ~last[0] & last_q[0];
  assign fs_lvl    = last[1];
  assign pdn_lvl   = last[2];
  assign and_rise  = (last[0] & last[1]) & ~(last_q[0] & last_q[1]);
endmodule

// File: rtl/pcm_bus_guard.sv
module pcm_bus_guard #(
  parameter int FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic frame_evt,
  output logic armed
);
  localparam int CW = (FRAMES < 1) ? 1 : $clog2(FRAMES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FRAMES);

  logic [CW-1:0] cnt;

  assign armed = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (frame_evt && !armed) cnt <= cnt + 1'b1;
  end

  // R2: guard count advances one step per silent frame start
  p_guard_step_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_evt && !armed && !clr) |=> (cnt == $past(cnt) + 1'b1));

  // R2: count never passes the limit
  p_guard_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
endmodule

// File: rtl/pcm_word_shifter.sv
module pcm_word_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         start_i,
  input  logic         shift_i,
  input  logic         clr_i,
  output logic         msb_o
);
  logic [W-1:0] hold;
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)         hold <= '0;
    else if (load_i) hold <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) sh <= '0;
    else if (start_i) sh <= hold;
    else if (shift_i) sh <= {sh[W-2:0], 1'b0};
  end

  assign msb_o = sh[W-1];

  // R8: the stored word, not the live input, is what a frame starts with
  p_capture_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && !clr_i) |=> (msb_o == $past(hold[W-1])));
endmodule

// File: rtl/pcm_word_tx.sv
module pcm_word_tx
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W       = 8,
  parameter int GUARD_FRAMES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              long_mode,
  input  logic              pdn,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int CNT_W = (WORD_W < 2) ? 1 : $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic bc_rise, bc_fall, fs_s, and_rise, pdn_s, armed;
  logic start, shift, endf, gevt;
  logic en_q, en_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  tx_state_e st_q, st_n;

  pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_i(bclk), .fs_i(fsync), .pdn_i(pdn),
    .bclk_rise(bc_rise), .bclk_fall(bc_fall), .fs_lvl(fs_s),
    .and_rise(and_rise), .pdn_lvl(pdn_s)
  );

  pcm_bus_guard #(.FRAMES(GUARD_FRAMES)) u_guard (
    .clk(clk), .rst(rst), .clr(pdn_s), .frame_evt(gevt), .armed(armed)
  );

  pcm_word_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(load), .data_i(din),
    .start_i(start), .shift_i(shift), .clr_i(endf), .msb_o(sdo)
  );

  always_comb begin
    st_n  = st_q;
    en_n  = en_q;
    cnt_n = cnt_q;
    start = 1'b0;
    shift = 1'b0;
    endf  = 1'b0;
    gevt  = 1'b0;
    if (pdn_s) begin
      st_n  = ST_IDLE;
      en_n  = 1'b0;
      endf  = 1'b1;
      cnt_n = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (long_mode) begin
            if (and_rise) begin
              gevt = 1'b1;
              if (armed) begin
                st_n  = ST_SEND;
                en_n  = 1'b1;
                start = 1'b1;
                cnt_n = '0;
              end else begin
                st_n = ST_TAIL;
              end
            end
          end else if (bc_fall && fs_s) begin
            gevt = 1'b1;
            if (armed) st_n = ST_PEND;
          end
        end
        ST_PEND: begin
          if (bc_rise) begin
            st_n  = ST_SEND;
            en_n  = 1'b1;
            start = 1'b1;
            cnt_n = '0;
          end
        end
        ST_SEND: begin
          if (bc_rise && cnt_q != LAST) begin
            shift = 1'b1;
            cnt_n = cnt_q + 1'b1;
          end else if (bc_fall && cnt_q == LAST) begin
            if (long_mode && fs_s) begin
              st_n = ST_TAIL;
            end else begin
              st_n = ST_IDLE;
              en_n = 1'b0;
              endf = 1'b1;
            end
          end
        end
        default: begin
          if (!fs_s) begin
            st_n = ST_IDLE;
            en_n = 1'b0;
            endf = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      en_q  <= en_n;
      cnt_q <= cnt_n;
    end
  end

  assign sdo_en = en_q;

  // R9: power-down silences the driver on the next cycle
  p_pdn_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    pdn_s |=> !sdo_en);

  // R2: the driver is never on while the guard is still counting
  p_guard_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !sdo_en);

  // R3: long timing opens only on the joint rise of sync and clock
  p_long_open_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(sdo_en) && $past(long_mode)) |-> $past(and_rise));

  // R5: short timing opens only on a rising clock edge
  p_short_open_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(sdo_en) && !$past(long_mode)) |-> $past(bc_rise));

  // R4, R6: the driver closes only at a clock fall, sync fall or power-down
  p_close_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sdo_en) |-> ($past(pdn_s) || $past(bc_fall) || !$past(fs_s)));

  // R11: no data while the driver is off
  p_idle_low_r11: assert property (@(posedge clk) disable iff (rst)
    !sdo_en |-> !sdo);

  // R7: data only moves with a rising clock edge
  p_bit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sdo_en && $past(sdo_en) && !$past(bc_rise)) |-> $stable(sdo));
endmodule

// File: tb/pcm_word_tx_test.sv
`timescale 1ns/1ps
module pcm_word_tx_test;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [7:0] din = 8'h00;
  logic bclk = 1'b0;
  logic fsync = 1'b0;
  logic long_mode = 1'b1;
  logic pdn = 1'b0;
  logic sdo, sdo_en;

  always #2 clk = ~clk;

  pcm_word_tx #(.WORD_W(8), .GUARD_FRAMES(2), .SYNC_STAGES(N)) uut (
    .clk(clk), .rst(rst), .load(load), .din(din), .bclk(bclk), .fsync(fsync),
    .long_mode(long_mode), .pdn(pdn), .sdo(sdo), .sdo_en(sdo_en)
  );

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_state = 0, m_bits = 0, m_guard = 0, rise_age = 99;
  bit m_en = 0, m_sdo = 0, pb = 0, pf = 0;
  logic [7:0] m_hold = 0, m_word = 0;
  logic [1:0] expq [$];

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_bits = 0; m_guard = 0; m_en = 0; m_sdo = 0;
      pb = 0; pf = 0; m_hold = 0; m_word = 0;
    end else begin
      bit b, f, r, fl, ar;
      b = bclk; f = fsync;
      r = b & !pb; fl = !b & pb; ar = (b & f) & !(pb & pf);
      if (load) m_hold = din;
      if (r) rise_age = 0; else if (rise_age < 99) rise_age++;
      if (pdn) begin
        m_state = 0; m_en = 0; m_sdo = 0; m_guard = 0;
      end else if (m_state == 0) begin
        if (long_mode && ar) begin
          if (m_guard >= 2) begin
            m_state = 2; m_word = m_hold; m_bits = 0; m_en = 1; m_sdo = m_word[7];
          end else begin
            m_guard++; m_state = 3;
          end
        end else if (!long_mode && fl && f) begin
          if (m_guard >= 2) m_state = 1; else m_guard++;
        end
      end else if (m_state == 1) begin
        if (r) begin
          m_state = 2; m_word = m_hold; m_bits = 0; m_en = 1; m_sdo = m_word[7];
        end
      end else if (m_state == 2) begin
        if (r && m_bits < 7) begin
          m_bits++; m_sdo = m_word[7 - m_bits];
        end else if (fl && m_bits == 7) begin
          if (long_mode && f) m_state = 3;
          else begin m_state = 0; m_en = 0; m_sdo = 0; end
        end
      end else begin
        if (!f) begin m_state = 0; m_en = 0; m_sdo = 0; end
      end
      pb = b; pf = f;
    end
    expq.push_back({m_en, m_sdo});
    if (expq.size() > N + 1) void'(expq.pop_front());
  end

  // per-cycle comparison (R10 latency) and frame monitor
  int en_len = 0, nbits = 0, frames = 0, last_len = 0;
  logic [7:0] cap = 0, last_word = 0;
  bit prev_en = 0;

  always @(negedge clk) begin
    if (!rst && expq.size() == N + 1) begin
      chk({phase, "/R10"}, {sdo_en, sdo}, expq[0]);
      if (!sdo_en) chk("R11", sdo, 0);
    end
    if (sdo_en) begin
      en_len++;
      if (rise_age == N && nbits < 8) begin cap = {cap[6:0], sdo}; nbits++; end
    end else if (prev_en) begin
      last_word = cap; last_len = en_len; frames++;
      en_len = 0; nbits = 0;
    end
    prev_en = sdo_en;
  end

  task automatic bitc(input bit ld, input logic [7:0] v);
    bclk = 1'b1;
    if (ld) begin din = v; load = 1'b1; end
    @(negedge clk); load = 1'b0;
    repeat (3) @(negedge clk);
    bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic long_frame(input int hold_bits, input int ld_at, input logic [7:0] v);
    fsync = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      if (i == hold_bits) fsync = 1'b0;
      bitc(i == ld_at, v);
    end
    fsync = 1'b0;
    repeat (4) bitc(0, 0);
  endtask

  task automatic short_frame(input int ld_at, input logic [7:0] v, input int pd_at);
    fsync = 1'b1;
    bclk = 1'b1; repeat (4) @(negedge clk);
    bclk = 1'b0; repeat (2) @(negedge clk);
    fsync = 1'b0; repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      if (i == pd_at) pdn = 1'b1;
      bitc(i == ld_at, v);
    end
    repeat (2) bitc(0, 0);
  endtask

  task automatic put(input logic [7:0] v);
    din = v; load = 1'b1; @(negedge clk); load = 1'b0; @(negedge clk);
  endtask

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    chk("R1 reset en", sdo_en, 0);
    chk("R1 reset sdo", sdo, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 idle en", sdo_en, 0);

    phase = "R2"; long_mode = 1'b1; put(8'hA5);
    long_frame(2, 99, 0); long_frame(2, 99, 0);
    chk("R2 guard frames", frames, 0);

    phase = "R3"; long_frame(2, 99, 0);
    chk("R3 frame sent", frames, 1);
    chk("R7 word long", last_word, 8'hA5);
    chk("R4 mid-LSB close", last_len, 60);

    phase = "R4"; put(8'h3C); long_frame(12, 99, 0);
    chk("R4 sync-held word", last_word, 8'h3C);
    chk("R4 sync fall close", last_len, 96);

    phase = "R5"; long_mode = 1'b0; put(8'h81);
    short_frame(99, 0, 99);
    chk("R5 short word", last_word, 8'h81);
    chk("R6 short close", last_len, 60);

    phase = "R8"; put(8'h5A);
    short_frame(3, 8'hF0, 99);
    chk("R8 old word kept", last_word, 8'h5A);
    short_frame(99, 0, 99);
    chk("R8 new word next", last_word, 8'hF0);

    phase = "R9"; f0 = frames;
    short_frame(99, 0, 3);
    chk("R9 aborted frame", frames, f0 + 1);
    chk("R9 abort length", last_len, 24);
    chk("R9 quiet in pdn", sdo_en, 0);
    pdn = 1'b0; repeat (2) bitc(0, 0);
    phase = "R2";
    short_frame(99, 0, 99); short_frame(99, 0, 99);
    chk("R2 guard after pdn", frames, f0 + 1);
    short_frame(99, 0, 99);
    chk("R2 sent after guard", frames, f0 + 2);
    chk("R7 word after guard", last_word, 8'hF0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule